// File: doc/BRIEF.md
# Ring Stop with Injection Control

This block is one stop on a unidirectional ring. A single pipeline register sits on the ring path, so a flit moves forward by one stop each clock. The stop compares the destination field of each arriving ring flit with its own constant stop number. A flit addressed to this stop is pushed into a small local receive queue. Any other flit is passed on to the next stop. A local source can put new flits onto the ring through a valid/ready port, but it can only use a slot that is leaving the stop empty.

Flits already on the ring always come before local injection. If a flit reaches its destination while the receive queue is full, it is not dropped and the ring does not stall. The flit goes round the ring again, and its bounce count goes up by one so that repeated misses can be seen. When a flit is ejected, its slot is freed in that same cycle, and the local source can fill it.

Top module: `ring_stop`

## Requirements
- R1: After a synchronous active-low reset, `ring_out_valid` is 0, `rx_valid` is 0 and the receive queue is empty.
- R2: A valid ring flit whose destination differs from `MY_ID` appears on the `ring_out_*` outputs one cycle later. Its destination, payload and bounce count are unchanged.
- R3: A valid ring flit addressed to `MY_ID` that arrives while the queue is not full is removed from the ring. Its payload and bounce count then appear at the `rx_*` port in arrival order.
- R4: While a ring flit is being forwarded, `inj_ready` is 0 and the local flit is not taken. The ring flit occupies the outgoing slot.
- R5: When the ring input is idle, `inj_ready` is 1. An offered local flit then appears on `ring_out_*` one cycle later with bounce count 0.
- R6: In the cycle a ring flit is ejected, `inj_ready` is 1, and an offered local flit takes the freed slot.
- R7: A ring flit addressed to `MY_ID` that arrives while the queue holds `RXQ_DEPTH` entries is forwarded one cycle later with its bounce count incremented by one. `inj_ready` is 0 in that cycle.
- R8: The bounce count saturates at its all-ones value (15 at the default width of 4 bits).
- R9: The queue accepts exactly `RXQ_DEPTH` (default 4) flits without a read. It returns them first-in first-out through `rx_valid`/`rx_ready`.
- R10: With the ring input idle and no local flit offered, `ring_out_valid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ring_in_valid | input | 1 | Upstream slot holds a flit |
| ring_in_dest | input | ID_W | Destination stop of upstream flit |
| ring_in_bounce | input | BOUNCE_W | Bounce count of upstream flit |
| ring_in_data | input | DATA_W | Payload of upstream flit |
| ring_out_valid | output | 1 | Outgoing slot holds a flit |
| ring_out_dest | output | ID_W | Destination of outgoing flit |
| ring_out_bounce | output | BOUNCE_W | Bounce count of outgoing flit |
| ring_out_data | output | DATA_W | Payload of outgoing flit |
| inj_valid | input | 1 | Local source offers a flit |
| inj_ready | output | 1 | Outgoing slot is free this cycle |
| inj_dest | input | ID_W | Destination of local flit |
| inj_data | input | DATA_W | Payload of local flit |
| rx_valid | output | 1 | Receive queue not empty |
| rx_ready | input | 1 | Local consumer takes the head entry |
| rx_bounce | output | BOUNCE_W | Bounce count of head entry |
| rx_data | output | DATA_W | Payload of head entry |

## Verification
The hardest case to reach is a flit addressed to this stop arriving while the receive queue is full, with a local flit waiting at the same time. The stimulus creates it by holding `rx_ready` low while it sends addressed flits until the queue is full. It then presents one more addressed flit together with an injection request. A further addressed flit already carrying the maximum bounce count exercises saturation. After the queue drains, the bounced flit is presented again to confirm that the retry succeeds.

// File: rtl/ring_stop_pkg.sv
// Shared types for the ring stop: which source fills the outgoing slot.
package ring_stop_pkg;
    typedef enum logic [1:0] {
        SLOT_EMPTY  = 2'd0,  // nothing leaves the stop
        SLOT_PASS   = 2'd1,  // foreign ring flit passes through
        SLOT_BOUNCE = 2'd2,  // addressed flit goes around again
        SLOT_LOCAL  = 2'd3   // local injection fills the slot
    } slot_src_e;
endpackage

// File: rtl/ring_stop_decide.sv
// Slot arbitration for one ring stop.
// Decides, from the current upstream flit, queue fullness and the local
// request, who owns the outgoing slot and whether a flit is ejected.
// Assumes: purely combinational; ring traffic always outranks injection.
module ring_stop_decide
    import ring_stop_pkg::*;
#(
    parameter int ID_W  = 3,
    parameter int MY_ID = 2
) (
    input  logic            ring_valid,
    input  logic [ID_W-1:0] ring_dest,
    input  logic            q_full,
    input  logic            inj_valid,
    output logic            eject,
    output logic            inj_ready,
    output slot_src_e       slot_src
);
    localparam logic [ID_W-1:0] MY_ID_L = ID_W'(MY_ID);

    logic for_me;

    // Choose the slot owner with the ring taking precedence.
    always_comb begin
        for_me    = ring_valid && (ring_dest == MY_ID_L);
        eject     = for_me && !q_full;
        inj_ready = !ring_valid || eject;
        if (ring_valid && !for_me)
            slot_src = SLOT_PASS;
        else if (for_me && q_full)
            slot_src = SLOT_BOUNCE;
        else if (inj_valid)
            slot_src = SLOT_LOCAL;
        else
            slot_src = SLOT_EMPTY;
    end
endmodule

// File: rtl/ring_stop_slot.sv
// Ring pipeline register for one stop.
// Loads the outgoing slot from the chosen source; a bounced flit gets its
// bounce count raised by one, saturating at all ones.
// Assumes: synchronous active-low reset clears only the valid bit.
module ring_stop_slot
    import ring_stop_pkg::*;
#(
    parameter int ID_W     = 3,
    parameter int DATA_W   = 16,
    parameter int BOUNCE_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  slot_src_e           slot_src,
    input  logic [ID_W-1:0]     ring_dest,
    input  logic [BOUNCE_W-1:0] ring_bounce,
    input  logic [DATA_W-1:0]   ring_data,
    input  logic [ID_W-1:0]     inj_dest,
    input  logic [DATA_W-1:0]   inj_data,
    output logic                out_valid,
    output logic [ID_W-1:0]     out_dest,
    output logic [BOUNCE_W-1:0] out_bounce,
    output logic [DATA_W-1:0]   out_data
);
    localparam logic [BOUNCE_W-1:0] BOUNCE_MAX = '1;

    logic [BOUNCE_W-1:0] bounce_inc;

    // Saturating increment of the bounce count.
    always_comb begin
        bounce_inc = (ring_bounce == BOUNCE_MAX) ? BOUNCE_MAX : ring_bounce + 1'b1;
    end

    // Valid bit of the slot register.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= (slot_src != SLOT_EMPTY);
    end

    // Fields of the slot register, loaded from the winning source.
    always_ff @(posedge clk) begin
        case (slot_src)
            SLOT_PASS: begin
                out_dest   <= ring_dest;
                out_bounce <= ring_bounce;
                out_data   <= ring_data;
            end
            SLOT_BOUNCE: begin
                out_dest   <= ring_dest;
                out_bounce <= bounce_inc;
                out_data   <= ring_data;
            end
            SLOT_LOCAL: begin
                out_dest   <= inj_dest;
                out_bounce <= '0;
                out_data   <= inj_data;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ring_stop_fifo.sv
// Receive queue for flits ejected at this stop.
// Circular buffer with a registered full flag; head entry shown on rd_*.
// Assumes: the writer never pushes while full; a pop does not free space
// for a push in the same cycle as seen through the full flag.
module ring_stop_fifo #(
    parameter int WIDTH = 20,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wr_data,
    output logic             full,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [WIDTH-1:0] rd_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    // Qualify the two handshakes.
    always_comb begin
        do_push = push && !full;
        do_pop  = rd_valid && rd_ready;
    end

    assign full     = (count == FULL_CNT);
    assign rd_valid = (count != '0);
    assign rd_data  = mem[rd_ptr];

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wr_data;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ring_stop.sv
// One stop of a unidirectional ring.
// Forwards foreign flits through a one-cycle slot register, ejects flits
// addressed to MY_ID into a receive queue, bounces them when the queue is
// full, and lets a local source fill slots that would otherwise leave empty.
// Assumes: single clock, synchronous active-low reset.
module ring_stop
    import ring_stop_pkg::*;
#(
    parameter int ID_W      = 3,
    parameter int MY_ID     = 2,
    parameter int DATA_W    = 16,
    parameter int BOUNCE_W  = 4,
    parameter int RXQ_DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ring_in_valid,
    input  logic [ID_W-1:0]     ring_in_dest,
    input  logic [BOUNCE_W-1:0] ring_in_bounce,
    input  logic [DATA_W-1:0]   ring_in_data,
    output logic                ring_out_valid,
    output logic [ID_W-1:0]     ring_out_dest,
    output logic [BOUNCE_W-1:0] ring_out_bounce,
    output logic [DATA_W-1:0]   ring_out_data,
    input  logic                inj_valid,
    output logic                inj_ready,
    input  logic [ID_W-1:0]     inj_dest,
    input  logic [DATA_W-1:0]   inj_data,
    output logic                rx_valid,
    input  logic                rx_ready,
    output logic [BOUNCE_W-1:0] rx_bounce,
    output logic [DATA_W-1:0]   rx_data
);
    localparam int ENTRY_W = DATA_W + BOUNCE_W;

    slot_src_e          slot_src;
    logic               q_full;
    logic               q_push;
    logic [ENTRY_W-1:0] q_head;

    ring_stop_decide #(.ID_W(ID_W), .MY_ID(MY_ID)) u_decide (
        .ring_valid (ring_in_valid),
        .ring_dest  (ring_in_dest),
        .q_full     (q_full),
        .inj_valid  (inj_valid),
        .eject      (q_push),
        .inj_ready  (inj_ready),
        .slot_src   (slot_src)
    );

    ring_stop_slot #(.ID_W(ID_W), .DATA_W(DATA_W), .BOUNCE_W(BOUNCE_W)) u_slot (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot_src    (slot_src),
        .ring_dest   (ring_in_dest),
        .ring_bounce (ring_in_bounce),
        .ring_data   (ring_in_data),
        .inj_dest    (inj_dest),
        .inj_data    (inj_data),
        .out_valid   (ring_out_valid),
        .out_dest    (ring_out_dest),
        .out_bounce  (ring_out_bounce),
        .out_data    (ring_out_data)
    );

    ring_stop_fifo #(.WIDTH(ENTRY_W), .DEPTH(RXQ_DEPTH)) u_rxq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (q_push),
        .wr_data  ({ring_in_bounce, ring_in_data}),
        .full     (q_full),
        .rd_valid (rx_valid),
        .rd_ready (rx_ready),
        .rd_data  (q_head)
    );

    assign {rx_bounce, rx_data} = q_head;
endmodule

// File: rtl/ring_stop_chk.sv
// Property checker for ring_stop, attached by bind below.
module ring_stop_chk #(
    parameter int ID_W     = 3,
    parameter int MY_ID    = 2,
    parameter int DATA_W   = 16,
    parameter int BOUNCE_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ring_in_valid,
    input logic [ID_W-1:0]     ring_in_dest,
    input logic [BOUNCE_W-1:0] ring_in_bounce,
    input logic [DATA_W-1:0]   ring_in_data,
    input logic                ring_out_valid,
    input logic [BOUNCE_W-1:0] ring_out_bounce,
    input logic [DATA_W-1:0]   ring_out_data,
    input logic                inj_valid,
    input logic                inj_ready,
    input logic                q_full,
    input logic                q_push
);
    localparam logic [ID_W-1:0] ME = ID_W'(MY_ID);

    // R2
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ring_in_valid && ring_in_dest != ME |=>
            ring_out_valid && ring_out_data == $past(ring_in_data)
            && ring_out_bounce == $past(ring_in_bounce));

    // R4
    ring_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ring_in_valid && ring_in_dest != ME |-> !inj_ready);

    // R5
    inject_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inj_valid && inj_ready |=> ring_out_valid && ring_out_bounce == '0);

    // R7
    bounce_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ring_in_valid && ring_in_dest == ME && q_full |=>
            ring_out_valid && ring_out_data == $past(ring_in_data));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(q_push && q_full));

    // R10
    idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ring_in_valid && !inj_valid |=> !ring_out_valid);
endmodule

bind ring_stop ring_stop_chk #(
    .ID_W(ID_W), .MY_ID(MY_ID), .DATA_W(DATA_W), .BOUNCE_W(BOUNCE_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .ring_in_valid   (ring_in_valid),
    .ring_in_dest    (ring_in_dest),
    .ring_in_bounce  (ring_in_bounce),
    .ring_in_data    (ring_in_data),
    .ring_out_valid  (ring_out_valid),
    .ring_out_bounce (ring_out_bounce),
    .ring_out_data   (ring_out_data),
    .inj_valid       (inj_valid),
    .inj_ready       (inj_ready),
    .q_full          (q_full),
    .q_push          (q_push)
);

// File: tb/ring_stop_bench.sv
`timescale 1ns/1ps
module ring_stop_bench;
    localparam int ID_W = 3, MY_ID = 2, DATA_W = 16, BOUNCE_W = 4, DEPTH = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ring_in_valid = 1'b0;
    logic [ID_W-1:0] ring_in_dest = '0;
    logic [BOUNCE_W-1:0] ring_in_bounce = '0;
    logic [DATA_W-1:0] ring_in_data = '0;
    logic ring_out_valid;
    logic [ID_W-1:0] ring_out_dest;
    logic [BOUNCE_W-1:0] ring_out_bounce;
    logic [DATA_W-1:0] ring_out_data;
    logic inj_valid = 1'b0, inj_ready;
    logic [ID_W-1:0] inj_dest = '0;
    logic [DATA_W-1:0] inj_data = '0;
    logic rx_valid, rx_ready = 1'b0;
    logic [BOUNCE_W-1:0] rx_bounce;
    logic [DATA_W-1:0] rx_data;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ring_stop #(.ID_W(ID_W), .MY_ID(MY_ID), .DATA_W(DATA_W),
                .BOUNCE_W(BOUNCE_W), .RXQ_DEPTH(DEPTH)) u_ring_stop (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Advance one clock; inputs set before, outputs read after (at negedge).
    task automatic step();
        @(negedge clk);
    endtask

    task automatic ring_drive(input bit v, input int dest, input int b, input int d);
        ring_in_valid = v; ring_in_dest = ID_W'(dest);
        ring_in_bounce = BOUNCE_W'(b); ring_in_data = DATA_W'(d);
    endtask

    task automatic t_reset();
        chk(ring_out_valid == 1'b0, "R1", "ring_out_valid", ring_out_valid, 0);
        chk(rx_valid == 1'b0, "R1", "rx_valid", rx_valid, 0);
        #1;
        chk(inj_ready == 1'b1, "R5", "inj_ready idle", inj_ready, 1);
    endtask

    task automatic t_forward();
        ring_drive(1, 5, 2, 'hA5A5);
        inj_valid = 1; inj_dest = 3; inj_data = 'h7777;
        #1;
        chk(inj_ready == 1'b0, "R4", "inj_ready while forwarding", inj_ready, 0);
        step();
        chk(ring_out_valid && ring_out_dest == 5, "R2", "forwarded dest", ring_out_dest, 5);
        chk(ring_out_data == 'hA5A5, "R2", "forwarded data", ring_out_data, 'hA5A5);
        chk(ring_out_bounce == 2, "R2", "forwarded bounce", ring_out_bounce, 2);
        ring_drive(0, 0, 0, 0);
        #1;
        chk(inj_ready == 1'b1, "R5", "inj_ready after ring idle", inj_ready, 1);
        step();
        chk(ring_out_valid && ring_out_data == 'h7777, "R5", "waiting flit injected",
            ring_out_data, 'h7777);
        chk(ring_out_bounce == 0 && ring_out_dest == 3, "R5", "injected bounce",
            ring_out_bounce, 0);
        inj_valid = 0;
        step();
        chk(ring_out_valid == 1'b0, "R10", "idle slot", ring_out_valid, 0);
    endtask

    task automatic t_eject_swap();
        ring_drive(1, MY_ID, 3, 'h0101);
        inj_valid = 1; inj_dest = 6; inj_data = 'h2222;
        #1;
        chk(inj_ready == 1'b1, "R6", "inj_ready on eject", inj_ready, 1);
        step();
        chk(ring_out_valid && ring_out_data == 'h2222, "R6", "freed slot filled",
            ring_out_data, 'h2222);
        chk(rx_valid && rx_data == 'h0101, "R3", "ejected head", rx_data, 'h0101);
        chk(rx_bounce == 3, "R3", "ejected bounce", rx_bounce, 3);
        inj_valid = 0;
    endtask

    task automatic t_full_bounce();
        for (int i = 2; i <= DEPTH; i++) begin
            ring_drive(1, MY_ID, 0, 'h0100 + i);
            step();
            chk(ring_out_valid == 1'b0, "R3", "addressed flit left ring", ring_out_valid, 0);
        end
        ring_drive(1, MY_ID, 1, 'h0105);
        inj_valid = 1; inj_data = 'h3333;
        #1;
        chk(inj_ready == 1'b0, "R7", "inj_ready while bouncing", inj_ready, 0);
        step();
        chk(ring_out_valid && ring_out_data == 'h0105, "R7", "bounced data",
            ring_out_data, 'h0105);
        chk(ring_out_bounce == 2, "R7", "bounce incremented", ring_out_bounce, 2);
        chk(ring_out_dest == MY_ID, "R7", "bounced dest", ring_out_dest, MY_ID);
        inj_valid = 0;
        ring_drive(1, MY_ID, 15, 'h0106);
        step();
        chk(ring_out_bounce == 15, "R8", "bounce saturates", ring_out_bounce, 15);
        ring_drive(0, 0, 0, 0);
    endtask

    task automatic t_drain_retry();
        rx_ready = 1;
        for (int i = 1; i <= DEPTH; i++) begin
            chk(rx_valid && rx_data == 'h0100 + i, "R9", "queue order", rx_data, 'h0100 + i);
            step();
        end
        chk(rx_valid == 1'b0, "R9", "queue empty after depth reads", rx_valid, 0);
        rx_ready = 0;
        ring_drive(1, MY_ID, 2, 'h0105);
        step();
        ring_drive(0, 0, 0, 0);
        chk(ring_out_valid == 1'b0, "R7", "retry ejected", ring_out_valid, 0);
        chk(rx_valid && rx_data == 'h0105 && rx_bounce == 2, "R7", "retry payload",
            rx_data, 'h0105);
    endtask

    initial begin
        repeat (3) step();
        t_reset();
        rst_n = 1;
        step();
        t_reset();
        t_forward();
        t_eject_swap();
        t_full_bounce();
        t_drain_retry();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule